// File: doc/BRIEF.md
# Serial-Loaded Eight-Channel Switch Controller

This block is the digital control core of an eight-channel low-side switch. A host loads one control bit per channel over a serial data and serial clock pair into a shift register. Pulsing a strobe line copies that pattern into an output buffer, and the buffer drives the channels. A serial output presents the last shift stage, so further serial devices can be chained behind this one and loaded by one longer burst with a shared strobe.

Each channel has an over-current input. A trip turns that channel off and pulls a shared active-low fault flag. The channel stays off and the flag stays low until the next strobe. An unsigned temperature code is compared against a trip point and a lower release point. Crossing the trip point forces every channel off until the code drops below the release point. This thermal state does not touch the fault flag. An active-low enable gates all channels at once. All serial-side inputs are synchronised to the system clock, and the power-on reset starts the block with everything off.

Top module: `sldc_top`

## Requirements
- R1: On each rising edge of the serial clock the shift register moves up one stage and takes the serial data bit into stage 0. After eight clocks, the first bit sent sits in stage 7 and the last bit sent sits in stage 0.
- R2: While strobe is high, the output buffer follows the shift register. While strobe is low, the buffer holds its value, so shifting without a strobe leaves the channel drives unchanged.
- R3: Buffer bit i controls channel output drive_o[i]. A 1 turns the channel on and a 0 turns it off.
- R4: While the active-low enable is high, every drive is 0. The buffer keeps its contents, so pulling enable low again restores the previous drives.
- R5: An over-current on a channel that is currently on turns that channel off. The other channels keep their drives. An over-current on a channel that is off has no effect.
- R6: A tripped channel stays off after its over-current input goes away. The next rising strobe clears the trip, and the channel then follows its buffer bit again.
- R7: The fault flag fault_n_o goes low when any channel trips. It stays low until the next rising strobe, then returns high.
- R8: When the temperature code reaches TRIP_C (default 155), all drives go to 0 and hot_o goes high. Both hold while the code is at or above TRIP_C-HYST_C (default 145). The drives return once the code falls below that value.
- R9: Thermal shutdown never pulls the fault flag low.
- R10: After power-on reset, all drives are 0, the fault flag is high, the serial output is 0 and hot_o is low.
- R11: The serial output always shows the last shift stage (stage 7). It shows the first bit of a byte once that byte has been shifted in, and one clock later it shows the byte's second bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| strobe_i | input | 1 | Buffer load strobe, asynchronous |
| en_n_i | input | 1 | Global channel enable, active low, asynchronous |
| ovc_i | input | NUM_CH | Per-channel over-current indication, synchronous |
| temp_i | input | TEMP_W | Unsigned die temperature code in degrees Celsius |
| drive_o | output | NUM_CH | Channel on/off drives |
| ser_dat_o | output | 1 | Last shift stage, for cascading |
| fault_n_o | output | 1 | Over-current fault flag, active low |
| hot_o | output | 1 | Thermal shutdown active |

## Verification
The bench builds the block with its defaults: eight channels, two synchroniser stages, an 8-bit temperature code, a trip point of 155 and a hysteresis of 10. These values put both thermal boundaries within reach: 154 against 155 on the way up, and 145 against 144 on the way down. A full eight-bit frame lets the bench check that the first bit sent lands in the top channel. The bench can also follow that first bit onto the cascade output, then shift one bit further and see the byte's second bit appear there.

// File: rtl/sldc_pkg.sv
package sldc_pkg;
   typedef enum logic {
      TH_NORMAL   = 1'b0,
      TH_SHUTDOWN = 1'b1
   } therm_state_e;
endpackage

// File: rtl/sldc_sync.sv
module sldc_sync #(
   parameter int unsigned     W       = 1,
   parameter int unsigned     STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sldc_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/sldc_shift.sv
module sldc_shift #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         sdi,
   input  logic         load,
   output logic [N-1:0] buf_q,
   output logic         sdo
);
   if (N < 2) begin : g_bad_n
      $error("sldc_shift: N must be at least 2");
   end

   logic [N-1:0] sreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
      end else if (shift_en) begin
         sreg <= {sreg[N-2:0], sdi};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
      end else if (load) begin
         buf_q <= sreg;
      end
   end

   assign sdo = sreg[N-1];

   p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> sreg[0] == $past(sdi));

   p_buf_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(buf_q));
endmodule

// File: rtl/sldc_chan.sv
module sldc_chan (
   input  logic clk,
   input  logic rst_n,
   input  logic want,
   input  logic allow,
   input  logic ovc,
   input  logic clr,
   output logic drv
);
   logic trip_q;

   assign drv = want & allow & ~trip_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trip_q <= 1'b0;
      end else begin
         trip_q <= (ovc & drv) | (trip_q & ~clr);
      end
   end

   p_trip_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovc && drv) |=> !drv);

   p_trip_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!drv && !clr && $past(ovc && drv)) |=> !drv);
endmodule

// File: rtl/sldc_therm.sv
module sldc_therm
   import sldc_pkg::*;
#(
   parameter int unsigned TEMP_W = 8,
   parameter int unsigned TRIP_C = 155,
   parameter int unsigned HYST_C = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TEMP_W-1:0] temp,
   output logic              hot
);
   localparam int unsigned REL_C = TRIP_C - HYST_C;

   if (HYST_C == 0 || HYST_C > TRIP_C) begin : g_bad_hyst
      $error("sldc_therm: HYST_C must be in 1..TRIP_C");
   end
   if (TRIP_C >= (1 << TEMP_W)) begin : g_bad_trip
      $error("sldc_therm: TRIP_C does not fit TEMP_W bits");
   end

   localparam logic [TEMP_W-1:0] TRIP_V = TEMP_W'(TRIP_C);
   localparam logic [TEMP_W-1:0] REL_V  = TEMP_W'(REL_C);

   therm_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         TH_NORMAL:   if (temp >= TRIP_V) st_d = TH_SHUTDOWN;
         TH_SHUTDOWN: if (temp <  REL_V)  st_d = TH_NORMAL;
         default:     st_d = TH_NORMAL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= TH_NORMAL;
      else        st_q <= st_d;
   end

   assign hot = (st_q == TH_SHUTDOWN);

   p_hot_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hot && temp >= REL_V) |=> hot);

   p_cool_stay_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!hot && temp < TRIP_V) |=> !hot);
endmodule

// File: rtl/sldc_top.sv
module sldc_top #(
   parameter int unsigned NUM_CH      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TEMP_W      = 8,
   parameter int unsigned TRIP_C      = 155,
   parameter int unsigned HYST_C      = 10
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              ser_clk_i,
   input  logic              ser_dat_i,
   input  logic              strobe_i,
   input  logic              en_n_i,
   input  logic [NUM_CH-1:0] ovc_i,
   input  logic [TEMP_W-1:0] temp_i,
   output logic [NUM_CH-1:0] drive_o,
   output logic              ser_dat_o,
   output logic              fault_n_o,
   output logic              hot_o
);
   localparam int unsigned    NSYNC    = 4;
   localparam logic [NSYNC-1:0] SYNC_RST = 4'b1000;
   localparam logic [TEMP_W-1:0] TRIP_V = TEMP_W'(TRIP_C);

   logic [NSYNC-1:0] raw_in, syn;
   logic sck_s, sdi_s, stb_s, en_n_s;
   logic sck_d, stb_d;
   logic sck_rise, stb_rise;
   logic allow;
   logic fault_q;
   logic [NUM_CH-1:0] buf_q;

   assign raw_in = {en_n_i, strobe_i, ser_dat_i, ser_clk_i};

   sldc_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk   (clk),
      .rst_n (por_n),
      .d     (raw_in),
      .q     (syn)
   );

   assign sck_s  = syn[0];
   assign sdi_s  = syn[1];
   assign stb_s  = syn[2];
   assign en_n_s = syn[3];

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sck_d <= 1'b0;
         stb_d <= 1'b0;
      end else begin
         sck_d <= sck_s;
         stb_d <= stb_s;
      end
   end

   assign sck_rise = sck_s & ~sck_d;
   assign stb_rise = stb_s & ~stb_d;

   sldc_shift #(.N(NUM_CH)) u_shift (
      .clk      (clk),
      .rst_n    (por_n),
      .shift_en (sck_rise),
      .sdi      (sdi_s),
      .load     (stb_s),
      .buf_q    (buf_q),
      .sdo      (ser_dat_o)
   );

   sldc_therm #(.TEMP_W(TEMP_W), .TRIP_C(TRIP_C), .HYST_C(HYST_C)) u_therm (
      .clk   (clk),
      .rst_n (por_n),
      .temp  (temp_i),
      .hot   (hot_o)
   );

   assign allow = ~en_n_s & ~hot_o;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      sldc_chan u_chan (
         .clk   (clk),
         .rst_n (por_n),
         .want  (buf_q[i]),
         .allow (allow),
         .ovc   (ovc_i[i]),
         .clr   (stb_rise),
         .drv   (drive_o[i])
      );
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) fault_q <= 1'b0;
      else        fault_q <= (|(ovc_i & drive_o)) | (fault_q & ~stb_rise);
   end

   assign fault_n_o = ~fault_q;

   p_fault_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
      (!fault_n_o && !stb_rise) |=> !fault_n_o);

   p_fault_set_r7: assert property (@(posedge clk) disable iff (!por_n)
      (|(ovc_i & drive_o)) |=> !fault_n_o);

   p_hot_off_r8: assert property (@(posedge clk) disable iff (!por_n)
      (temp_i >= TRIP_V) |=> drive_o == '0);

   p_dis_off_r4: assert property (@(posedge clk) disable iff (!por_n)
      $past(en_n_i) && en_n_s |-> drive_o == '0);
endmodule

// File: tb/sldc_top_tb.sv
`timescale 1ns/1ps
module sldc_top_tb;
   localparam int N = 8;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic sck = 1'b0, sdi = 1'b0, stb = 1'b0, en_n = 1'b0;
   logic [N-1:0] ovc = '0;
   logic [7:0] temp = 8'd25;
   logic [N-1:0] drive;
   logic sdo, fault_n, hot;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sldc_top u_dut (
      .clk(clk), .por_n(por_n), .ser_clk_i(sck), .ser_dat_i(sdi),
      .strobe_i(stb), .en_n_i(en_n), .ovc_i(ovc), .temp_i(temp),
      .drive_o(drive), .ser_dat_o(sdo), .fault_n_o(fault_n), .hot_o(hot)
   );

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      sdi = b; wclk(2);
      sck = 1'b1; wclk(4);
      sck = 1'b0; wclk(3);
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
   endtask

   task automatic pulse_strobe();
      stb = 1'b1; wclk(5);
      stb = 1'b0; wclk(5);
   endtask

   task automatic t_reset();
      check("R10 drive", drive, 0);
      check("R10 fault", fault_n, 1);
      check("R10 sdo", sdo, 0);
      check("R10 hot", hot, 0);
   endtask

   task automatic t_load(input logic [7:0] b);
      send_byte(b);
      pulse_strobe();
      check("R1 R3 load", drive, b);
   endtask

   task automatic t_hold_cascade();
      t_load(8'hA5);
      send_byte(8'h5A);
      check("R2 hold without strobe", drive, 8'hA5);
      check("R11 first bit on sdo", sdo, 0);
      send_bit(1'b0);
      check("R11 second bit on sdo", sdo, 1);
   endtask

   task automatic t_transparent();
      t_load(8'h00);
      send_byte(8'h0F);
      stb = 1'b1; wclk(5);
      check("R2 follows while high", drive, 8'h0F);
      send_bit(1'b1);
      check("R2 tracks shift", drive, 8'h1F);
      stb = 1'b0; wclk(5);
   endtask

   task automatic t_enable();
      t_load(8'h3C);
      en_n = 1'b1; wclk(5);
      check("R4 disabled", drive, 0);
      en_n = 1'b0; wclk(5);
      check("R4 restored", drive, 8'h3C);
   endtask

   task automatic t_overcurrent();
      t_load(8'hFE);
      ovc = 8'h01; wclk(3); ovc = '0; wclk(2);
      check("R5 off channel ignored", drive, 8'hFE);
      check("R5 no fault from off channel", fault_n, 1);
      t_load(8'hFF);
      ovc = 8'h04; wclk(3); ovc = '0; wclk(3);
      check("R5 only channel 2 off", drive, 8'hFB);
      check("R7 fault low", fault_n, 0);
      wclk(10);
      check("R6 stays latched", drive, 8'hFB);
      check("R7 fault held", fault_n, 0);
      pulse_strobe();
      check("R6 strobe clears", drive, 8'hFF);
      check("R7 strobe clears fault", fault_n, 1);
   endtask

   task automatic t_thermal();
      t_load(8'hFF);
      temp = 8'd154; wclk(3);
      check("R8 below trip", drive, 8'hFF);
      temp = 8'd155; wclk(3);
      check("R8 trip off", drive, 0);
      check("R8 hot", hot, 1);
      check("R9 no fault", fault_n, 1);
      temp = 8'd145; wclk(3);
      check("R8 hysteresis hold", drive, 0);
      temp = 8'd144; wclk(3);
      check("R8 release", drive, 8'hFF);
      check("R8 hot cleared", hot, 0);
   endtask

   initial begin
      wclk(3);
      por_n = 1'b1;
      wclk(3);
      t_reset();
      t_load(8'h01);
      t_load(8'h80);
      t_load(8'hA5);
      t_hold_cascade();
      t_transparent();
      t_enable();
      t_overcurrent();
      t_thermal();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule